// File: doc/BRIEF.md
# Triplicated Three-Stage Pipeline with Cross-Voted Stage Boundaries

This block carries a 16-bit data word through a three-stage registered transform. It builds the whole pipeline three times over. A single input bus feeds all three copies. Every path has its own majority voter at each internal stage boundary. Each of those voters reads the matching stage register from all three paths. An upset in one copy of a stage is therefore outvoted before it reaches the next stage. Because the voters are repeated per path, the pipeline also tolerates several upsets at once, as long as no two of them hit the same stage section in the same cycle. A single voter after the last stage drives the output.

The first stage adds a constant to the word. The second stage rotates the voted word left and XORs in a second constant. The third stage is a plain register. Any voter whose three inputs differ sets a sticky disagreement flag. The flag stays set until a synchronous reset or an explicit clear. It can be read during idle periods as a sign that at least one upset was absorbed.

For testing, one strobe per path and stage XORs a shared mask into that register for a single cycle. A testbench can then place faults anywhere in the pipeline and watch how they are masked.

Top module: `voted_tmr_pipe`

## Requirements
- R1: With no injection, `dataOut` after clock edge n equals `rotl(d + ADD_CONST, ROT_AMT) ^ XOR_CONST`, where d is the word sampled on `dataIn` at edge n-2 (three register stages). Just after reset, the stages start from zero, so the first two outputs are 0 and then `XOR_CONST`.
- R2: A fault strobe on any single path of any single stage, with any mask, never changes `dataOut`.
- R3: Faults in different stage sections in the same cycle are all masked, whether they lie in different paths or in one path. Strobe bit `stage*3 + path` selects the register, with stage 0 being the adder stage.
- R4: Equal faults in two paths of the last stage in the same cycle reach the output. `dataOut` then equals the correct value XOR the mask for exactly that cycle and is correct again after the next edge.
- R5: A disagreement lasts one cycle only. After the flag that a single fault raised is cleared, it does not set again when no further fault is injected.
- R6: `errSticky` is 0 just after the edge that injects a non-zero mask. It reads 1 after the following edge.
- R7: Once set, `errSticky` stays 1 across clean cycles until `errClear` or reset is sampled at an edge. It is then 0.
- R8: When `errClear` and a disagreement coincide at an edge, the clear wins and `errSticky` reads 0.
- R9: While `rst_n` is low, all stage registers and the flag reset at each edge, and fault strobes have no effect. After reset, `dataOut` and `errSticky` are 0.
- R10: Fault strobes with an all-zero mask neither change `dataOut` nor set `errSticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dataIn | input | W | Untriplicated input word, fanned out to all paths |
| injSel | input | 9 | Fault strobes, bit `stage*3 + path` |
| injMask | input | W | XOR mask applied to every strobed register |
| errClear | input | 1 | Synchronous clear of the sticky flag |
| dataOut | output | W | Final voted output word |
| errSticky | output | 1 | Sticky flag, set by any voter disagreement |

## Verification
The bench places faults in every one of the nine registers in turn. It also places several faults in separate sections in one cycle, which catches cross-connections that were wired to the wrong path or a voter that passes only its own path. It puts two equal faults into the last stage on purpose and expects the corruption on exactly one output cycle, which exposes a voter that is not a true majority or a latency that is off by one. It pins the flag to its exact setting cycle, tests that a clear wins over a coincident mismatch, and tests that a cleared flag stays clear, which catches a flag that never clears or that copies the live mismatch.

// File: rtl/tmr_pipe_pkg.sv
package tmr_pipe_pkg;
  localparam int NPATH  = 3;
  localparam int NSTAGE = 3;
  localparam int NREG   = NPATH * NSTAGE;
  localparam int NVOTE  = NPATH * (NSTAGE - 1) + 1;

  // Strobes from control to datapath: bit stage*NPATH + path flips that register.
  typedef struct packed {
    logic [NREG-1:0] flip;
  } strobe_t;
endpackage

// File: rtl/tmr_voter3.sv
module tmr_voter3 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic         split
);
  assign y     = (a & b) | (b & c) | (a & c);
  assign split = (a != b) || (b != c);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pipe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREG-1:0]  injSel,
  input  logic             errClear,
  input  logic [NVOTE-1:0] split,
  output strobe_t          strobes,
  output logic             errSticky
);
  logic anySplit;

  // Strobes are masked while reset is held (R9).
  assign strobes.flip = rst_n ? injSel : '0;
  assign anySplit     = |split;

  always_ff @(posedge clk) begin
    if (!rst_n)        errSticky <= 1'b0;
    else if (errClear) errSticky <= 1'b0;
    else if (anySplit) errSticky <= 1'b1;
  end

  p_flag_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (anySplit && !errClear) |=> errSticky);

  p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (errSticky && !errClear) |=> errSticky);

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    errClear |=> !errSticky);

  p_reset_clears_r9: assert property (@(posedge clk)
    !rst_n |=> !errSticky);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pipe_pkg::*;
#(
  parameter int           W         = 16,
  parameter logic [W-1:0] ADD_CONST = 16'h3C5A,
  parameter int           ROT_AMT   = 5,
  parameter logic [W-1:0] XOR_CONST = 16'hA5A5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     dataIn,
  input  logic [W-1:0]     injMask,
  input  strobe_t          strobes,
  output logic [W-1:0]     dataOut,
  output logic [NVOTE-1:0] split
);
  localparam int NMID = NPATH * (NSTAGE - 1);

  logic [NREG*W-1:0] regFlat;
  logic [NMID*W-1:0] voteFlat;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x);
    return (x << ROT_AMT) | (x >> (W - ROT_AMT));
  endfunction

  for (genvar gs = 0; gs < NSTAGE; gs++) begin : g_stage
    for (genvar gp = 0; gp < NPATH; gp++) begin : g_path
      localparam int IDX = gs * NPATH + gp;
      logic [W-1:0] src, nxt, q;

      if (gs == 0) begin : g_fan
        assign src = dataIn;
      end else begin : g_voted
        assign src = voteFlat[((gs - 1) * NPATH + gp)*W +: W];
      end

      if (gs == 0) begin : g_add
        assign nxt = src + ADD_CONST;
      end else if (gs == 1) begin : g_rot
        assign nxt = rotl(src) ^ XOR_CONST;
      end else begin : g_pass
        assign nxt = src;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt ^ (strobes.flip[IDX] ? injMask : '0);
      end
      assign regFlat[IDX*W +: W] = q;

      if (gs < NSTAGE - 1) begin : g_vote
        tmr_voter3 #(.W(W)) u_vote (
          .a    (regFlat[(gs*NPATH + 0)*W +: W]),
          .b    (regFlat[(gs*NPATH + 1)*W +: W]),
          .c    (regFlat[(gs*NPATH + 2)*W +: W]),
          .y    (voteFlat[IDX*W +: W]),
          .split(split[IDX])
        );
      end
    end
  end

  tmr_voter3 #(.W(W)) u_final (
    .a    (regFlat[((NSTAGE-1)*NPATH + 0)*W +: W]),
    .b    (regFlat[((NSTAGE-1)*NPATH + 1)*W +: W]),
    .c    (regFlat[((NSTAGE-1)*NPATH + 2)*W +: W]),
    .y    (dataOut),
    .split(split[NVOTE-1])
  );

  // All copies of every stage agree unless a strobe fired at the previous edge.
  logic pathsAgree;
  always_comb begin
    pathsAgree = 1'b1;
    for (int s = 0; s < NSTAGE; s++) begin
      for (int p = 1; p < NPATH; p++) begin
        if (regFlat[(s*NPATH + p)*W +: W] != regFlat[(s*NPATH)*W +: W])
          pathsAgree = 1'b0;
      end
    end
  end

  p_paths_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobes.flip) == '0) |-> pathsAgree);
endmodule

// File: rtl/voted_tmr_pipe.sv
module voted_tmr_pipe
  import tmr_pipe_pkg::*;
#(
  parameter int           W         = 16,
  parameter logic [W-1:0] ADD_CONST = 16'h3C5A,
  parameter int           ROT_AMT   = 5,
  parameter logic [W-1:0] XOR_CONST = 16'hA5A5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    dataIn,
  input  logic [NREG-1:0] injSel,
  input  logic [W-1:0]    injMask,
  input  logic            errClear,
  output logic [W-1:0]    dataOut,
  output logic            errSticky
);
  strobe_t          strobes;
  logic [NVOTE-1:0] split;

  tmr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .injSel   (injSel),
    .errClear (errClear),
    .split    (split),
    .strobes  (strobes),
    .errSticky(errSticky)
  );

  tmr_datapath #(
    .W(W), .ADD_CONST(ADD_CONST), .ROT_AMT(ROT_AMT), .XOR_CONST(XOR_CONST)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .dataIn (dataIn),
    .injMask(injMask),
    .strobes(strobes),
    .dataOut(dataOut),
    .split  (split)
  );
endmodule

// File: tb/voted_tmr_pipe_bench.sv
`timescale 1ns/1ps
module voted_tmr_pipe_bench;
  localparam logic [15:0] K_ADD = 16'h3C5A;
  localparam int          K_ROT = 5;
  localparam logic [15:0] K_XOR = 16'hA5A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dataIn = '0;
  logic [8:0]  injSel = '0;
  logic [15:0] injMask = '0;
  logic        errClear = 1'b0;
  logic [15:0] dataOut;
  logic        errSticky;

  int total = 0;
  int fails = 0;
  logic [15:0] m0 = '0, m1 = '0, m2 = '0;

  always #4 clk = ~clk;

  voted_tmr_pipe #(.W(16), .ADD_CONST(K_ADD), .ROT_AMT(K_ROT), .XOR_CONST(K_XOR)) u_voted_tmr_pipe (
    .clk(clk), .rst_n(rst_n), .dataIn(dataIn), .injSel(injSel), .injMask(injMask),
    .errClear(errClear), .dataOut(dataOut), .errSticky(errSticky)
  );

  function automatic logic [15:0] rl(input logic [15:0] x);
    return (x << K_ROT) | (x >> (16 - K_ROT));
  endfunction

  task automatic tick(input logic [15:0] d, input logic [8:0] sel = '0,
                      input logic [15:0] mask = '0, input logic clr = 1'b0);
    @(negedge clk);
    dataIn = d; injSel = sel; injMask = mask; errClear = clr;
    @(posedge clk);
    if (!rst_n) begin
      m2 = '0; m1 = '0; m0 = '0;
    end else begin
      m2 = m1; m1 = rl(m0) ^ K_XOR; m0 = d + K_ADD;
    end
    #1;
  endtask

  task automatic chkOut(input string tag, input logic [15:0] flipExp = '0);
    total++;
    if (dataOut !== (m2 ^ flipExp)) begin
      fails++;
      $display("FAIL %s: dataOut=%h expected %h", tag, dataOut, m2 ^ flipExp);
    end
  endtask

  task automatic chkFlag(input string tag, input logic exp);
    total++;
    if (errSticky !== exp) begin
      fails++;
      $display("FAIL %s: errSticky=%b expected %b", tag, errSticky, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(16'hBEEF, 9'h1FF, 16'hFFFF);
    tick(16'h1111, 9'h1FF, 16'hFFFF);
    tick(16'h2222, 9'h1FF, 16'hFFFF);
    chkOut("R9 reset output");
    chkFlag("R9 reset flag", 1'b0);
    rst_n = 1'b1;
    tick(16'h0001); chkOut("R9 first output after reset"); chkFlag("R9 strobes in reset ignored", 1'b0);
    tick(16'h0002); chkOut("R1 second output after reset");
  endtask

  task automatic t_clean();
    logic [15:0] pats [8] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h1234,
                              16'hC3A5, 16'h7FFF, 16'h5555, 16'hAAAA};
    for (int i = 0; i < 8; i++) begin
      tick(pats[i]); chkOut("R1 clean stream");
    end
    tick(16'h0F0F); chkOut("R1 drain");
    tick(16'hF0F0); chkOut("R1 drain");
    chkFlag("R1 no flag when clean", 1'b0);
  endtask

  task automatic t_flag();
    tick(16'h1357, '0, '0, 1'b1);
    tick(16'h2468, 9'h010, 16'h0100);
    chkFlag("R6 not set at inject edge", 1'b0);
    tick(16'h3579); chkFlag("R6 set one edge later", 1'b1);
    for (int i = 0; i < 3; i++) begin
      tick(16'h4000 + 16'(i)); chkFlag("R7 sticky across clean cycles", 1'b1);
    end
    tick(16'h5A5A, '0, '0, 1'b1); chkFlag("R7 cleared by errClear", 1'b0);
    tick(16'h6B6B); chkFlag("R5 disagreement gone after one cycle", 1'b0);
    tick(16'h7C7C); chkFlag("R5 flag stays clear", 1'b0); chkOut("R5 output after fault");
  endtask

  task automatic t_clear_wins();
    tick(16'h0A0A, 9'h001, 16'hFFFF);
    tick(16'h0B0B, '0, '0, 1'b1); chkFlag("R8 clear beats coincident mismatch", 1'b0);
    tick(16'h0C0C); chkFlag("R8 stays clear", 1'b0);
  endtask

  task automatic t_zero_mask();
    tick(16'h9999, 9'h1FF, 16'h0000); chkOut("R10 zero mask output");
    tick(16'h8888, 9'h1FF, 16'h0000); chkOut("R10 zero mask output");
    tick(16'h7777); chkFlag("R10 zero mask no flag", 1'b0); chkOut("R10 zero mask output");
  endtask

  task automatic t_single();
    for (int b = 0; b < 9; b++) begin
      tick(16'h1000 + 16'(b), 9'(1 << b), 16'hFFFF ^ 16'(b)); chkOut("R2 single fault");
      for (int k = 0; k < 3; k++) begin
        tick(16'h2000 + 16'(b * 7 + k)); chkOut("R2 single fault");
      end
    end
  endtask

  task automatic t_spread();
    tick(16'hA1A1, 9'b100_010_001, 16'hFFFF); chkOut("R3 spread faults, diagonal");
    for (int k = 0; k < 3; k++) begin tick(16'hA2A2 + 16'(k)); chkOut("R3 spread faults, diagonal"); end
    tick(16'hB1B1, 9'b001_001_001, 16'h5A5A); chkOut("R3 one path every stage");
    for (int k = 0; k < 3; k++) begin tick(16'hB2B2 + 16'(k)); chkOut("R3 one path every stage"); end
  endtask

  task automatic t_same_section();
    tick(16'hC0DE); chkOut("R4 before");
    tick(16'hC1DE, 9'b011_000_000, 16'h00F0); chkOut("R4 two faults in last stage pass", 16'h00F0);
    tick(16'hC2DE); chkOut("R4 recovered after one cycle");
  endtask

  initial begin
    #(8 * 100000);
    fails++; total++;
    $display("FAIL watchdog: finished=0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_clean();
    t_flag();
    t_clear_wins();
    t_zero_mask();
    t_single();
    t_spread();
    t_same_section();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule